// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache

This block is the read path of a small cache that sits between a processor read port and a main-memory block-fetch port. A request carries a byte address. The block splits that address into three fields: a tag, a set index and a byte-in-line offset. It then reads both lines of the indexed set at once and compares their stored tags against the request tag.

When a valid line matches, the requested byte is returned from that line and memory is not involved. When neither line matches, the block asks memory for the whole 4-byte block. It installs the block in one line of the set and answers the original request from the returned data.

Each line carries a valid flag, and all flags are cleared by reset. Each set keeps a single bit that names its least recently used line, and that bit decides which line a fill displaces. A line that is not valid is always chosen before a valid one. While a request is in progress the port reports busy, and new requests are not taken.

The split is set by parameters. With a 24-bit address and a 13-bit index the tag is 9 bits wide and the data store holds 64 KB. The default build uses a 10-bit index so that the elaborated arrays stay small.

Top module: `cache2w_rd`

## Requirements
- R1: The address fields are: offset = rd_addr[1:0], set index = rd_addr[IDX_W+1:2], tag = the remaining upper bits. Two addresses that differ only in their tag map to the same set.
- R2: Synchronous active-high reset clears every valid flag and every LRU bit, and drives rd_busy, rd_done, rd_hit and mem_req low. The first read of any address after reset is a miss.
- R3: A read of a resident block is a hit. rd_done and rd_hit are high on the second rising edge after the edge that accepts the request, no mem_req is raised, and rd_data is the byte at the offset.
- R4: On a miss, mem_req rises one edge after the lookup. mem_addr carries the request address with its two low bits forced to zero. mem_req stays high until mem_valid is sampled.
- R5: Byte k of a block travels on bits [8k+7:8k] of mem_data and of the stored line. On the edge where mem_valid is sampled, the block is installed and rd_done is raised with rd_hit low. rd_data then carries the requested byte of the returned block.
- R6: Two blocks that share a set index but differ in tag can be resident together, and both then hit.
- R7: A miss fills an invalid line of the set, way 0 first, before any valid line is displaced.
- R8: When both lines are valid, a miss replaces the line used least recently, counting both hits and fills as uses.
- R9: rd_req is ignored while rd_busy is high. Such a request yields no answer and fetches nothing.
- R10: rd_done is a single-cycle pulse, and rd_busy is low whenever rd_done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read request, taken when rd_busy is low |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_busy | output | 1 | A request is in progress |
| rd_done | output | 1 | One-cycle pulse: rd_data holds the answer |
| rd_hit | output | 1 | High with rd_done when the answer came from a resident line |
| rd_data | output | 8 | Byte returned to the processor |
| mem_req | output | 1 | Block fetch request, held until mem_valid |
| mem_addr | output | ADDR_W | Block-aligned fetch address |
| mem_valid | input | 1 | Fetched block is present on mem_data |
| mem_data | input | 8*LINE_BYTES | Fetched block, byte k in bits [8k+7:8k] |

## Verification
Installing a fetched block and answering the processor happen in the same cycle: the line is written and the byte is taken straight from mem_data on the edge where mem_valid is sampled. A fill is also the cycle in which the LRU bit of the set moves. Both are provoked by reading one byte of a block and then, right after, a different byte of the same block, and by misses that share a set. They are judged by checking each answer byte against the bench's own memory model, and by checking the hit or miss outcome predicted for every access in a fixed address sequence.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_FILL = 2'd2
  } cache_st_e;
endpackage

// File: rtl/cache2w_way.sv
module cache2w_way #(
  parameter int TAG_W  = 12,
  parameter int IDX_W  = 10,
  parameter int LINE_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [IDX_W-1:0]  look_idx,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line,
  output logic [TAG_W-1:0]  q_tag,
  output logic [LINE_W-1:0] q_line,
  output logic              q_vld
);
  localparam int SETS  = 1 << IDX_W;
  localparam int ENT_W = TAG_W + LINE_W;

  logic [ENT_W-1:0] store [SETS];
  logic [ENT_W-1:0] q_ent;
  logic [SETS-1:0]  vld_r;

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_idx] <= {wr_tag, wr_line};
    if (rd_en) q_ent <= store[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst)        vld_r <= '0;
    else if (wr_en) vld_r[wr_idx] <= 1'b1;
  end

  assign q_tag  = q_ent[ENT_W-1:LINE_W];
  assign q_line = q_ent[LINE_W-1:0];
  assign q_vld  = vld_r[look_idx];

  assert_fill_valid_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> vld_r[$past(wr_idx)]);
endmodule

// File: rtl/cache2w_lru.sv
module cache2w_lru #(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] look_idx,
  input  logic             upd_en,
  input  logic             upd_used,
  output logic             lru_way
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0] lru_r;

  always_ff @(posedge clk) begin
    if (rst)         lru_r <= '0;
    else if (upd_en) lru_r[look_idx] <= ~upd_used;
  end

  assign lru_way = lru_r[look_idx];
endmodule

// File: rtl/cache2w_rd.sv
module cache2w_rd
  import cache2w_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int IDX_W      = 10,
  parameter int LINE_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rd_req,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic                    rd_busy,
  output logic                    rd_done,
  output logic                    rd_hit,
  output logic [7:0]              rd_data,
  output logic                    mem_req,
  output logic [ADDR_W-1:0]       mem_addr,
  input  logic                    mem_valid,
  input  logic [8*LINE_BYTES-1:0] mem_data
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W = 8 * LINE_BYTES;
  localparam int WAYS   = 2;

  cache_st_e         state;
  logic [ADDR_W-1:0] addr_q;
  logic              vict_q;

  logic [OFF_W-1:0]  off_q;
  logic [IDX_W-1:0]  idx_q;
  logic [TAG_W-1:0]  tag_q;
  logic [IDX_W-1:0]  idx_in;

  assign off_q  = addr_q[OFF_W-1:0];
  assign idx_q  = addr_q[OFF_W +: IDX_W];
  assign tag_q  = addr_q[ADDR_W-1 -: TAG_W];
  assign idx_in = rd_addr[OFF_W +: IDX_W];

  logic [TAG_W-1:0]  w_tag  [WAYS];
  logic [LINE_W-1:0] w_line [WAYS];
  logic [WAYS-1:0]   w_vld;
  logic [WAYS-1:0]   w_hit;
  logic [WAYS-1:0]   w_wr;
  logic              accept, fill_now, lru_way, victim, upd_en, upd_used;

  assign accept   = (state == ST_IDLE) && rd_req;
  assign fill_now = (state == ST_FILL) && mem_valid;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign w_wr[w]  = fill_now && (vict_q == w[0]);
    assign w_hit[w] = w_vld[w] && (w_tag[w] == tag_q);

    cache2w_way #(.TAG_W(TAG_W), .IDX_W(IDX_W), .LINE_W(LINE_W)) u_way (
      .clk      (clk),
      .rst      (rst),
      .rd_en    (accept),
      .rd_idx   (idx_in),
      .look_idx (idx_q),
      .wr_en    (w_wr[w]),
      .wr_idx   (idx_q),
      .wr_tag   (tag_q),
      .wr_line  (mem_data),
      .q_tag    (w_tag[w]),
      .q_line   (w_line[w]),
      .q_vld    (w_vld[w])
    );
  end

  // invalid lines first (way 0 before way 1), then the LRU line
  assign victim   = !w_vld[0] ? 1'b0 : (!w_vld[1] ? 1'b1 : lru_way);
  assign upd_en   = ((state == ST_LOOK) && (|w_hit)) || fill_now;
  assign upd_used = (state == ST_LOOK) ? w_hit[1] : vict_q;

  cache2w_lru #(.IDX_W(IDX_W)) u_lru (
    .clk      (clk),
    .rst      (rst),
    .look_idx (idx_q),
    .upd_en   (upd_en),
    .upd_used (upd_used),
    .lru_way  (lru_way)
  );

  function automatic logic [7:0] pick_byte(input logic [LINE_W-1:0] line,
                                           input logic [OFF_W-1:0] off);
    return line[{off, 3'b000} +: 8];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      addr_q  <= '0;
      vict_q  <= 1'b0;
      rd_done <= 1'b0;
      rd_hit  <= 1'b0;
      rd_data <= '0;
      mem_req <= 1'b0;
    end else begin
      rd_done <= 1'b0;
      rd_hit  <= 1'b0;
      unique case (state)
        ST_IDLE: if (rd_req) begin
          addr_q <= rd_addr;
          state  <= ST_LOOK;
        end
        ST_LOOK: if (|w_hit) begin
          rd_done <= 1'b1;
          rd_hit  <= 1'b1;
          rd_data <= pick_byte(w_hit[1] ? w_line[1] : w_line[0], off_q);
          state   <= ST_IDLE;
        end else begin
          mem_req <= 1'b1;
          vict_q  <= victim;
          state   <= ST_FILL;
        end
        ST_FILL: if (mem_valid) begin
          mem_req <= 1'b0;
          rd_done <= 1'b1;
          rd_data <= pick_byte(mem_data, off_q);
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rd_busy  = (state != ST_IDLE);
  assign mem_addr = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  assert_one_way_hit_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOOK) |-> $onehot0(w_hit));
  assert_req_held_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_valid) |=> mem_req);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    rd_done |=> !rd_done);
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    rd_done |-> !rd_busy);
  assert_hit_no_fetch_R3: assert property (@(posedge clk) disable iff (rst)
    rd_hit |-> (!mem_req && rd_done));
endmodule

// File: tb/cache2w_rd_tb.sv
module cache2w_rd_tb;
  localparam int ADDR_W = 24;
  localparam int IDX_W  = 10;
  localparam int NVEC   = 15;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_req = 1'b0;
  logic [23:0] rd_addr = '0;
  logic        rd_busy, rd_done, rd_hit, mem_req;
  logic [7:0]  rd_data;
  logic [23:0] mem_addr;
  logic        mem_valid = 1'b0;
  logic [31:0] mem_data = '0;

  int n_tests = 0;
  int n_fail  = 0;
  int n_hits  = 0;
  int n_fetch = 0;

  always #10 clk = ~clk;

  cache2w_rd #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LINE_BYTES(4)) u_dut (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_busy(rd_busy), .rd_done(rd_done), .rd_hit(rd_hit), .rd_data(rd_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .mem_data(mem_data)
  );

  // {expect_hit, address}; sets chosen so that several tags share set 0x40
  localparam logic [24:0] VEC [NVEC] = '{
    {1'b0, 24'h000100}, {1'b1, 24'h000103}, {1'b0, 24'h001101},
    {1'b1, 24'h000102}, {1'b1, 24'h001100}, {1'b0, 24'h002100},
    {1'b1, 24'h001103}, {1'b0, 24'h000100}, {1'b0, 24'h002101},
    {1'b1, 24'h000101}, {1'b0, 24'h001102}, {1'b0, 24'hFFFFFF},
    {1'b1, 24'hFFFFFC}, {1'b0, 24'h000004}, {1'b1, 24'h000007}
  };

  function automatic logic [7:0] ref_byte(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory model: answers two cycles after a fetch request
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req && !mem_valid) begin
        n_fetch++;
        check(mem_addr[1:0] == 2'b00, "R4", "fetch alignment",
              {8'h0, mem_addr}, {8'h0, mem_addr[23:2], 2'b00});
        repeat (2) @(negedge clk);
        check(mem_req, "R4", "request held", {31'h0, mem_req}, 32'h1);
        mem_data  = {ref_byte({mem_addr[23:2], 2'd3}), ref_byte({mem_addr[23:2], 2'd2}),
                     ref_byte({mem_addr[23:2], 2'd1}), ref_byte({mem_addr[23:2], 2'd0})};
        mem_valid = 1'b1;
        @(negedge clk);
        mem_valid = 1'b0;
      end
    end
  end

  task automatic do_read(input logic [23:0] a, input bit exp_hit, input string req);
    int cyc = 0;
    @(negedge clk);
    rd_req  = 1'b1;
    rd_addr = a;
    @(negedge clk);
    rd_req = 1'b0;
    cyc = 1;
    while (!rd_done && cyc < 50) begin
      @(negedge clk);
      cyc++;
    end
    if (rd_hit) n_hits++;
    check(rd_hit == exp_hit, req, "hit flag", {31'h0, rd_hit}, {31'h0, exp_hit});
    check(rd_data == ref_byte(a), req, "data", {24'h0, rd_data}, {24'h0, ref_byte(a)});
    if (exp_hit)
      check(cyc == 2, "R3", "hit latency", cyc, 32'd2);
    @(negedge clk);
    check(!rd_done, "R10", "done pulse width", {31'h0, rd_done}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL all: watchdog expired, actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int exp_hits = 0;
    repeat (3) @(negedge clk);
    check({rd_busy, rd_done, rd_hit, mem_req} == 4'b0, "R2", "reset outputs",
          {28'h0, rd_busy, rd_done, rd_hit, mem_req}, 32'h0);
    rst = 1'b0;

    // table walk: R1 set mapping, R5 fill, R6 two ways, R7 invalid first, R8 LRU
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][24]) exp_hits++;
      do_read(VEC[i][23:0], VEC[i][24], "R1/R5-R8 vector");
    end
    check(n_hits == exp_hits, "R8", "hit count", n_hits, exp_hits);
    check(n_fetch == NVEC - exp_hits, "R3", "fetch count", n_fetch, NVEC - exp_hits);

    // R9: request raised during a fill is dropped
    @(negedge clk);
    rd_req = 1'b1; rd_addr = 24'h003200;
    @(negedge clk);
    rd_req = 1'b0;
    @(negedge clk);
    rd_req = 1'b1; rd_addr = 24'h004300;
    @(negedge clk);
    rd_req = 1'b0;
    while (!rd_done) @(negedge clk);
    check(rd_data == ref_byte(24'h003200), "R9", "answer of first request",
          {24'h0, rd_data}, {24'h0, ref_byte(24'h003200)});
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(!rd_done && !mem_req, "R9", "no trailing activity",
            {30'h0, rd_done, mem_req}, 32'h0);
    end
    do_read(24'h004300, 1'b0, "R9");

    // R2: reset mid-run invalidates resident lines
    do_read(24'h000005, 1'b1, "R3");
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check({rd_busy, rd_done, mem_req} == 3'b0, "R2", "outputs after reset",
          {29'h0, rd_busy, rd_done, mem_req}, 32'h0);
    do_read(24'h000005, 1'b0, "R2");
    do_read(24'h001104, 1'b0, "R2");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule